// File: doc/BRIEF.md
# Indirect Test-Pattern Buffer Loader

This block fills a write data buffer that holds memory test patterns. The buffer has 64 lines of 8 chunks, and each chunk is 64 bits wide. Software cannot reach the buffer directly. It writes the data through four 32-bit registers, one chunk at a time.

The loading order is fixed:
- the low data word,
- the high data word,
- a select word that names the chunk and the access mode,
- a command word that gives the line number and a write opcode.

The write opcode in the command word is what starts the commit. It takes effect only while the select word holds the write mode with the buffer as its target array.

The commit lands one cycle after the command write. While it is outstanding, a busy output is high. A command whose line or chunk lies outside the buffer writes nothing and raises an error output. A combinational readback port returns any chunk of any line, so a testbench can inspect the buffer contents.

Top module: `tbuf_load_port`

## Requirements
- R1: After reset, busy and err are 0, all four registers read 0, and every buffer chunk reads back as 0.
- R2: A write with reg_addr 0, 1, 2 or 3 loads the low data word, high data word, select word or command word respectively. rd_data returns the register named by rd_addr, and a register changes only when it is written.
- R3: A command write stores {high word, low word} at the line given by command bits 11:0 and the chunk given by select bits 3:0. It does so only when all of these hold: command bits 27:24 equal 4'b1000, select bits 17:16 equal 1, select bits 9:5 equal 0, and select bit 11 is 0.
- R4: After a qualifying command write at clock edge k, busy is high between edges k and k+1. The new chunk is visible on the readback port after edge k+1, and busy falls at that edge unless another qualifying command is written.
- R5: A command write that fails any condition of R3 writes nothing, leaves busy low and leaves err unchanged.
- R6: Once the select word is written to zero, later command writes are ignored. No chunk changes and busy stays low.
- R7: A qualifying command whose line is 64 or more (up to 0xFFF), or whose chunk is 8 or more, writes nothing. It sets err at the commit edge. The next in-range commit clears err.
- R8: Data and line are captured at the command write. A data write in the following cycle does not alter the pending commit, and no chunk other than the addressed one changes.
- R9: Select bits 10 and 15:12, command bits 16 through 19, and command bits 23:20 and 31:28 have no effect on whether or where a chunk is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register index: 0 low data, 1 high data, 2 select, 3 command |
| reg_wdata | input | 32 | Register write data |
| rd_addr | input | 2 | Register readback index |
| rd_data | output | 32 | Register readback value |
| busy | output | 1 | A commit is pending |
| err | output | 1 | The last commit was dropped as out of range |
| rb_line | input | 6 | Readback line |
| rb_chunk | input | 3 | Readback chunk |
| rb_data | output | 64 | Chunk contents at rb_line/rb_chunk |

## Verification
The assertions check four behaviours on every cycle:
- busy only rises after a command write;
- busy never lasts longer than one cycle unless another command is issued;
- a rejected or idle-mode command never raises busy;
- err only rises right after a pending commit.

Held registers are also checked to stay stable without a write. Only the bench's scenarios can show the remaining behaviours:
- the stored value lands at the right line and chunk;
- out-of-range commands leave the aliased locations untouched;
- ignored fields truly change nothing;
- data written after a command does not leak into the commit.

// File: rtl/tbuf_load_port.sv
module tbuf_load_port #(
  parameter int LINES  = 64,
  parameter int CHUNKS = 8,
  localparam int LINE_W  = $clog2(LINES),
  localparam int CHUNK_W = $clog2(CHUNKS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_we,
  input  logic [1:0]         reg_addr,
  input  logic [31:0]        reg_wdata,
  input  logic [1:0]         rd_addr,
  output logic [31:0]        rd_data,
  output logic               busy,
  output logic               err,
  input  logic [LINE_W-1:0]  rb_line,
  input  logic [CHUNK_W-1:0] rb_chunk,
  output logic [63:0]        rb_data
);
  localparam int IDX_W = LINE_W + CHUNK_W;
  localparam int DEPTH = LINES * CHUNKS;
  localparam logic [1:0] A_LO = 2'd0, A_HI = 2'd1, A_SEL = 2'd2, A_CMD = 2'd3;
  localparam logic [3:0] OP_WRITE = 4'b1000;

  logic [31:0] lo_q, hi_q, sel_q, cmd_q;
  logic        pend_q, pend_ok_q, err_q;
  logic [IDX_W-1:0] pend_idx_q;
  logic [63:0] pend_data_q;
  logic [63:0] mem [DEPTH];

  wire        cmd_wr   = reg_we && reg_addr == A_CMD;
  wire [3:0]  bank     = sel_q[3:0];
  wire [4:0]  arr_sel  = sel_q[9:5];
  wire        repl     = sel_q[11];
  wire [1:0]  mode     = sel_q[17:16];
  wire [11:0] fast     = reg_wdata[11:0];
  wire [3:0]  op_b     = reg_wdata[27:24];
  wire        launch   = cmd_wr && op_b == OP_WRITE && mode == 2'd1 &&
                         arr_sel == 5'd0 && !repl;
  wire        in_range = fast < 12'(LINES) && bank < 4'(CHUNKS);
  wire [IDX_W-1:0] idx = {fast[LINE_W-1:0], bank[CHUNK_W-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q  <= '0;
      hi_q  <= '0;
      sel_q <= '0;
      cmd_q <= '0;
    end else if (reg_we) begin
      case (reg_addr)
        A_LO:    lo_q  <= reg_wdata;
        A_HI:    hi_q  <= reg_wdata;
        A_SEL:   sel_q <= reg_wdata;
        default: cmd_q <= reg_wdata;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q      <= 1'b0;
      pend_ok_q   <= 1'b0;
      pend_idx_q  <= '0;
      pend_data_q <= '0;
    end else begin
      pend_q <= launch;
      if (launch) begin
        pend_ok_q   <= in_range;
        pend_idx_q  <= idx;
        pend_data_q <= {hi_q, lo_q};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      err_q <= 1'b0;
    else if (pend_q)
      err_q <= !pend_ok_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (pend_q && pend_ok_q) begin
      mem[pend_idx_q] <= pend_data_q;
    end
  end

  always_comb begin
    case (rd_addr)
      A_LO:    rd_data = lo_q;
      A_HI:    rd_data = hi_q;
      A_SEL:   rd_data = sel_q;
      default: rd_data = cmd_q;
    endcase
  end

  assign busy    = pend_q;
  assign err     = err_q;
  assign rb_data = mem[{rb_line, rb_chunk}];

  p_busy_from_cmd_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(reg_we && reg_addr == A_CMD));

  p_busy_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cmd_wr) |=> !busy);

  p_reject_op_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && reg_wdata[27:24] != OP_WRITE) |=> !busy);

  p_idle_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && sel_q == 32'd0) |=> !busy);

  p_err_after_commit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> $past(busy));

  p_regs_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_we |=> ($stable(lo_q) && $stable(hi_q) && $stable(sel_q) && $stable(cmd_q)));
endmodule

// File: tb/tbuf_load_port_tb_top.sv
module tbuf_load_port_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [1:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        busy, err;
  logic [5:0]  rb_line = '0;
  logic [2:0]  rb_chunk = '0;
  logic [63:0] rb_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [63:0] model [64][8];

  always #5 clk = ~clk;

  tbuf_load_port dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .rd_addr(rd_addr), .rd_data(rd_data),
    .busy(busy), .err(err), .rb_line(rb_line), .rb_chunk(rb_chunk),
    .rb_data(rb_data)
  );

  localparam int NV = 11;
  localparam logic [31:0] V_SEL [NV] = '{
    32'h0001_0000, 32'h0001_0007, 32'h0001_F403, 32'h0001_0003,
    32'h0002_0003, 32'h0001_0023, 32'h0001_0803, 32'h0001_0000,
    32'h0001_0008, 32'h0001_0001, 32'h0001_0000};
  localparam logic [31:0] V_CMD [NV] = '{
    32'h0800_0000, 32'h0800_003F, 32'hF8FF_0005, 32'h0400_0005,
    32'h0800_0005, 32'h0800_0005, 32'h0800_0005, 32'h0800_0040,
    32'h0800_0001, 32'h0800_0002, 32'h0800_0FFF};
  localparam bit V_WR [NV]  = '{1,1,1,0,0,0,0,0,0,1,0};
  localparam bit V_BSY [NV] = '{1,1,1,0,0,0,0,1,1,1,1};
  localparam bit V_ERR [NV] = '{0,0,0,0,0,0,0,1,1,0,1};
  localparam string V_REQ [NV] = '{"R3","R3","R9","R5","R5","R5","R5","R7","R7","R7","R7"};

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic peek(input int line, input int chunk, output logic [63:0] v);
    rb_line = 6'(line); rb_chunk = 3'(chunk);
    #1 v = rb_data;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    logic [63:0] v;
    for (int l = 0; l < 64; l++)
      for (int c = 0; c < 8; c++) model[l][c] = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 busy", 64'(busy), 0);
    chk("R1 err", 64'(err), 0);
    for (int a = 0; a < 4; a++) begin
      rd_addr = 2'(a); #1 chk("R1 reg", 64'(rd_data), 0);
    end
    peek(0, 0, v);  chk("R1 mem", v, 0);
    peek(63, 7, v); chk("R1 mem", v, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 register map
    wr(2'd0, 32'h1111_2222); wr(2'd1, 32'h3333_4444);
    wr(2'd2, 32'h0000_0000); wr(2'd3, 32'h0000_0123);
    rd_addr = 2'd0; #1 chk("R2 lo", 64'(rd_data), 64'h1111_2222);
    rd_addr = 2'd1; #1 chk("R2 hi", 64'(rd_data), 64'h3333_4444);
    rd_addr = 2'd2; #1 chk("R2 sel", 64'(rd_data), 0);
    rd_addr = 2'd3; #1 chk("R2 cmd", 64'(rd_data), 64'h0000_0123);

    // vector table
    for (int i = 0; i < NV; i++) begin
      logic [31:0] lo, hi;
      int line, chunk;
      lo = {8'hA5, 8'(i), 16'h1234};
      hi = {8'h5A, 8'(i), 16'hBEEF};
      line = int'(V_CMD[i][5:0]);
      chunk = int'(V_SEL[i][2:0]);
      wr(2'd0, lo); wr(2'd1, hi); wr(2'd2, V_SEL[i]); wr(2'd3, V_CMD[i]);
      chk({V_REQ[i], " R4 busy"}, 64'(busy), 64'(V_BSY[i]));
      @(negedge clk);
      chk({V_REQ[i], " busy low"}, 64'(busy), 0);
      chk({V_REQ[i], " err"}, 64'(err), 64'(V_ERR[i]));
      if (V_WR[i]) model[line][chunk] = {hi, lo};
      peek(line, chunk, v);
      chk({V_REQ[i], " data"}, v, model[line][chunk]);
    end

    // R8 capture at command, neighbours untouched
    wr(2'd0, 32'hDEAD_0001); wr(2'd1, 32'hC0DE_0001); wr(2'd2, 32'h0001_0004);
    wr(2'd3, 32'h0800_000A);
    wr(2'd0, 32'hFFFF_FFFF);
    model[10][4] = 64'hC0DE_0001_DEAD_0001;
    peek(10, 4, v); chk("R8 captured", v, model[10][4]);
    peek(10, 5, v); chk("R8 neighbour", v, 0);
    peek(11, 4, v); chk("R8 neighbour", v, 0);

    // R6 leaving access mode
    wr(2'd2, 32'h0000_0000);
    wr(2'd0, 32'h7777_7777);
    reg_we = 1'b1; reg_addr = 2'd3; reg_wdata = 32'h0800_000A;
    @(negedge clk); reg_we = 1'b0;
    chk("R6 busy", 64'(busy), 0);
    @(negedge clk);
    peek(10, 0, v); chk("R6 chunk0", v, 0);
    peek(10, 4, v); chk("R6 kept", v, model[10][4]);

    // R4 back-to-back commands keep busy high
    wr(2'd2, 32'h0001_0006); wr(2'd0, 32'h0000_00B1); wr(2'd1, 32'h0);
    wr(2'd3, 32'h0800_0014);
    chk("R4 busy first", 64'(busy), 1);
    wr(2'd3, 32'h0800_0015);
    chk("R4 busy second", 64'(busy), 1);
    peek(20, 6, v); chk("R4 first commit", v, 64'h0000_00B1);
    @(negedge clk);
    chk("R4 busy drop", 64'(busy), 0);
    peek(21, 6, v); chk("R4 second commit", v, 64'h0000_00B1);

    finish_run();
  end
endmodule